// File: doc/BRIEF.md
# Private Line and Software Interrupt Acceptor

This block sits beside one processor's interrupt state and turns two kinds of events into pending-bit set strobes. The first kind comes from the private peripheral input lines, which map to interrupt IDs 16 to 31. The second kind is a software-generated request for an ID from 0 to 15. Each software request carries the group it targets and a flag that marks it as coming from the non-secure side. The block never writes the pending bitmap itself. It emits a one-cycle set mask that the owning register bank ORs into that bitmap. It also exports the level it last saw on each line, so the bank can fold that level into its pending view for level-sensitive interrupts.

The configuration comes from the register bank as plain vectors:
- a group bit and a group-modifier bit for each interrupt;
- an edge/level selector for each interrupt;
- a 2-bit access level for each software interrupt;
- a global security-disable flag.

Non-secure software requests pass through the access-level filter. The level each request needs depends on the group the interrupt is configured into.

Top module: `ppi_sgi_acceptor`

## Requirements
- R1: `line_level` holds the value of `line_in` sampled at the previous rising clock edge. It reads zero out of reset.
- R2: A 0-to-1 change on line i, with `cfg_edge[16+i]` set to 1 (edge-triggered), produces `pend_set[16+i]` = 1 for exactly the next clock cycle.
- R3: A line produces no pending strobe in three cases: it is configured level-triggered (`cfg_edge` bit 0), it falls, or it does not change.
- R4: The configured group of interrupt n is coded 0 = group 0, 1 = secure group 1, 2 = non-secure group 1. `cfg_group[n]`=1 gives code 2. `cfg_group[n]`=0 gives code 1 when `cfg_grpmod[n]`=1 and security is enabled, and code 0 otherwise. With `sec_disable`=1 the modifier bit is ignored.
- R5: A request coded 1 (secure group 1) for an interrupt configured as group 0 is handled as a group-0 request.
- R6: A request whose group code, after the R5 adjustment, differs from the configured code is dropped. Request code 3 never matches.
- R7: The access level for software interrupt n is `cfg_access[2n+1:2n]`.
- R8: When `sgi_ns`=1 and `sec_disable`=0, the request is dropped in two cases: a group-0 interrupt has an access level of 0, or a secure group-1 interrupt has an access level below 2. Non-secure group-1 interrupts need no access level. Secure requests, and any request while security is disabled, skip this check.
- R9: An accepted request with ID n produces `pend_set[n]` = 1 for exactly one cycle, in the clock after it is presented. No other ID 0 to 15 is strobed. A cycle without `sgi_valid` strobes no ID 0 to 15.
- R10: While `rst_n` is low at a clock edge, `pend_set` and `line_level` are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 16 | Peripheral input lines, bit i is interrupt 16+i, synchronous to clk |
| sgi_valid | input | 1 | Software request present this cycle |
| sgi_id | input | 4 | Software interrupt ID 0 to 15 |
| sgi_grp | input | 2 | Requested group code (0, 1, 2 as in R4; 3 invalid) |
| sgi_ns | input | 1 | Request comes from the non-secure side |
| sec_disable | input | 1 | Single security state when 1 |
| cfg_group | input | 32 | Group bit per interrupt |
| cfg_grpmod | input | 32 | Group-modifier bit per interrupt |
| cfg_edge | input | 32 | 1 = edge-triggered, 0 = level-triggered, per interrupt |
| cfg_access | input | 32 | 2-bit access level per software interrupt |
| pend_set | output | 32 | One-cycle set mask for the pending bitmap |
| line_level | output | 16 | Stored line levels, bit i is interrupt 16+i |

## Verification
Both results are registered once, so each is due in the first cycle after its cause. The stored level follows a line one clock later. The strobe for an edge or an accepted request is also due one clock later and is gone again in the cycle after that. The bench drives each stimulus on a falling edge and lets exactly one rising edge pass. It then compares the whole strobe mask and the level vector on the next falling edge, before it drives anything new, so each result is matched to the single input cycle that caused it. Randomised configurations, lines and requests are mixed with directed cases for the group remap, the ignored modifier bit and the access-field position.

// File: rtl/irq_accept_pkg.sv
// Package irq_accept_pkg
// Shared group codes and the decode rule used by the acceptor.
// Assumes group bits and modifier bits come straight from the register bank.
package irq_accept_pkg;

    typedef enum logic [1:0] {
        GRP_G0   = 2'd0,
        GRP_G1S  = 2'd1,
        GRP_G1NS = 2'd2,
        GRP_BAD  = 2'd3
    } grp_code_e;

    // Turns one group bit and one modifier bit into a group code
    function automatic logic [1:0] decode_group(input logic grp_bit,
                                                input logic mod_bit,
                                                input logic sec_off);
        if (grp_bit)
            return GRP_G1NS;
        else if (mod_bit && !sec_off)
            return GRP_G1S;
        else
            return GRP_G0;
    endfunction

endpackage

// File: rtl/irq_group_map.sv
// Module irq_group_map
// Combinational decode of each interrupt's configured group code.
// Assumes: with security disabled the modifier bit carries no meaning.
module irq_group_map
    import irq_accept_pkg::*;
#(
    parameter int NUM_IRQ = 32
) (
    input  logic [NUM_IRQ-1:0]      grp_bits,
    input  logic [NUM_IRQ-1:0]      mod_bits,
    input  logic                    sec_off,
    output logic [NUM_IRQ-1:0][1:0] grp_code
);

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_dec
        // Decode one interrupt's group code
        always_comb begin
            grp_code[n] = decode_group(grp_bits[n], mod_bits[n], sec_off);
        end
    end

endmodule

// File: rtl/ppi_line_tracker.sv
// Module ppi_line_tracker
// Keeps the last sampled level of each peripheral line and strobes a
// pending set for rising edges on edge-configured lines.
// Assumes: lines are already synchronous to clk.
module ppi_line_tracker #(
    parameter int NUM_LINE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LINE-1:0] line_in,
    input  logic [NUM_LINE-1:0] edge_cfg,
    output logic [NUM_LINE-1:0] level_q,
    output logic [NUM_LINE-1:0] pend_line
);

    logic [NUM_LINE-1:0] changed;
    logic [NUM_LINE-1:0] rise_edge;

    // Find lines whose level differs from the stored copy
    always_comb begin
        changed   = line_in ^ level_q;
        rise_edge = changed & line_in & edge_cfg;
    end

    // Store levels and register the rise strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= '0;
            pend_line <= '0;
        end else begin
            level_q   <= line_in;
            pend_line <= rise_edge;
        end
    end

    // R1: stored level follows the line one clock later
    assert_level_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (level_q == $past(line_in)));

    for (genvar i = 0; i < NUM_LINE; i++) begin : g_chk
        // R2: edge-configured rising line strobes next cycle
        assert_rise_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && edge_cfg[i] && line_in[i] && !level_q[i]) |=> pend_line[i]);
        // R3: level-configured line never strobes
        assert_level_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_n && !edge_cfg[i]) |=> !pend_line[i]);
        // R2: the strobe lasts one cycle while the line stays high
        assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_line[i] && line_in[i]) |=> !pend_line[i]);
    end

endmodule

// File: rtl/sgi_admit.sv
// Module sgi_admit
// Filters one software interrupt request per clock by group and by the
// non-secure access level, and registers a one-hot pending strobe.
// Assumes: at most one request per cycle, ID already in range.
module sgi_admit
    import irq_accept_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int ACC_W   = 2,
    localparam int ID_W   = $clog2(NUM_SGI)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [ID_W-1:0]           req_id,
    input  logic [1:0]                req_grp,
    input  logic                      req_ns,
    input  logic                      sec_off,
    input  logic [NUM_SGI-1:0][1:0]   cfg_code,
    input  logic [NUM_SGI*ACC_W-1:0]  access_vec,
    output logic [NUM_SGI-1:0]        pend_sgi
);

    logic [NUM_SGI-1:0][ACC_W-1:0] acc_lv;
    logic [1:0]       tgt_code;
    logic [ACC_W-1:0] tgt_acc;
    logic [1:0]       eff_grp;
    logic             grp_ok;
    logic             acc_ok;
    logic             accept;

    for (genvar n = 0; n < NUM_SGI; n++) begin : g_acc
        // Slice the access level belonging to interrupt n
        always_comb acc_lv[n] = access_vec[n*ACC_W +: ACC_W];
    end

    // Look up the target's configuration and decide acceptance
    always_comb begin
        tgt_code = cfg_code[req_id];
        tgt_acc  = acc_lv[req_id];
        eff_grp  = ((req_grp == GRP_G1S) && (tgt_code == GRP_G0)) ? 2'(GRP_G0) : req_grp;
        grp_ok   = (eff_grp == tgt_code);
        acc_ok   = 1'b1;
        if (req_ns && !sec_off) begin
            if (tgt_code == GRP_G0)
                acc_ok = (tgt_acc >= ACC_W'(1));
            else if (tgt_code == GRP_G1S)
                acc_ok = (tgt_acc >= ACC_W'(2));
        end
        accept = req_valid && grp_ok && acc_ok;
    end

    // Register the one-hot pending strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_sgi <= '0;
        else if (accept)
            pend_sgi <= NUM_SGI'(1) << req_id;
        else
            pend_sgi <= '0;
    end

    // R9: never more than one software ID strobed
    assert_one_sgi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_sgi));
    // R9: no request, no strobe
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !req_valid) |=> (pend_sgi == '0));
    // R6: group mismatch after remap is dropped
    assert_grp_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && (req_grp != tgt_code) &&
         !((req_grp == GRP_G1S) && (tgt_code == GRP_G0))) |=> (pend_sgi == '0));
    // R8: non-secure access to secure group 1 needs level 2
    assert_acc_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && req_ns && !sec_off && (tgt_code == GRP_G1S) &&
         (acc_lv[req_id] < ACC_W'(2))) |=> (pend_sgi == '0));

endmodule

// File: rtl/ppi_sgi_acceptor.sv
// Module ppi_sgi_acceptor
// Top: merges peripheral-line edges and admitted software requests into
// one pending set mask; exports the stored line levels.
// Assumes: register bank ORs pend_set into its pending bitmap.
module ppi_sgi_acceptor
    import irq_accept_pkg::*;
#(
    parameter int NUM_SGI = 16,
    parameter int NUM_PPI = 16,
    parameter int ACC_W   = 2,
    localparam int NUM_IRQ = NUM_SGI + NUM_PPI,
    localparam int ID_W    = $clog2(NUM_SGI)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PPI-1:0]       line_in,
    input  logic                     sgi_valid,
    input  logic [ID_W-1:0]          sgi_id,
    input  logic [1:0]               sgi_grp,
    input  logic                     sgi_ns,
    input  logic                     sec_disable,
    input  logic [NUM_IRQ-1:0]       cfg_group,
    input  logic [NUM_IRQ-1:0]       cfg_grpmod,
    input  logic [NUM_IRQ-1:0]       cfg_edge,
    input  logic [NUM_SGI*ACC_W-1:0] cfg_access,
    output logic [NUM_IRQ-1:0]       pend_set,
    output logic [NUM_PPI-1:0]       line_level
);

    logic [NUM_IRQ-1:0][1:0] grp_code;
    logic [NUM_SGI-1:0][1:0] sgi_code;
    logic [NUM_PPI-1:0]      pend_line;
    logic [NUM_SGI-1:0]      pend_sgi;

    irq_group_map #(.NUM_IRQ(NUM_IRQ)) u_map (
        .grp_bits (cfg_group),
        .mod_bits (cfg_grpmod),
        .sec_off  (sec_disable),
        .grp_code (grp_code)
    );

    // Keep only the software-interrupt group codes
    always_comb sgi_code = grp_code[NUM_SGI-1:0];

    ppi_line_tracker #(.NUM_LINE(NUM_PPI)) u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .edge_cfg  (cfg_edge[NUM_IRQ-1:NUM_SGI]),
        .level_q   (line_level),
        .pend_line (pend_line)
    );

    sgi_admit #(.NUM_SGI(NUM_SGI), .ACC_W(ACC_W)) u_sgi (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (sgi_valid),
        .req_id     (sgi_id),
        .req_grp    (sgi_grp),
        .req_ns     (sgi_ns),
        .sec_off    (sec_disable),
        .cfg_code   (sgi_code),
        .access_vec (cfg_access),
        .pend_sgi   (pend_sgi)
    );

    // Merge both sources into the pending set mask
    always_comb pend_set = {pend_line, pend_sgi};

    // R10: reset clears every output
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> ((pend_set == '0) && (line_level == '0)));

endmodule

// File: tb/ppi_sgi_acceptor_tb.sv
module ppi_sgi_acceptor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_in = '0;
    logic        sgi_valid = 1'b0;
    logic [3:0]  sgi_id = '0;
    logic [1:0]  sgi_grp = '0;
    logic        sgi_ns = 1'b0;
    logic        sec_disable = 1'b0;
    logic [31:0] cfg_group = '0;
    logic [31:0] cfg_grpmod = '0;
    logic [31:0] cfg_edge = '0;
    logic [31:0] cfg_access = '0;
    logic [31:0] pend_set;
    logic [15:0] line_level;

    int tests = 0;
    int fails = 0;
    logic [15:0] mdl_level = '0;
    int unused_seed;

    always #2.5 clk = ~clk;

    ppi_sgi_acceptor u_dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .sgi_valid(sgi_valid),
        .sgi_id(sgi_id), .sgi_grp(sgi_grp), .sgi_ns(sgi_ns),
        .sec_disable(sec_disable), .cfg_group(cfg_group), .cfg_grpmod(cfg_grpmod),
        .cfg_edge(cfg_edge), .cfg_access(cfg_access), .pend_set(pend_set),
        .line_level(line_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Group code from requirement R4
    function automatic logic [1:0] cfg_code(input int n);
        if (cfg_group[n]) return 2'd2;
        if (cfg_grpmod[n] && !sec_disable) return 2'd1;
        return 2'd0;
    endfunction

    // Expected software strobe from R5, R6, R7, R8, R9
    function automatic logic [15:0] exp_sgi(output string tag);
        logic [1:0] c;
        logic [1:0] g;
        logic [1:0] a;
        tag = "R9";
        if (!sgi_valid) return '0;
        c = cfg_code(int'(sgi_id));
        g = sgi_grp;
        if (g == 2'd1 && c == 2'd0) begin g = 2'd0; tag = "R5"; end
        if (g != c) begin tag = "R6"; return '0; end
        a = cfg_access[2*sgi_id +: 2];
        if (sgi_ns && !sec_disable) begin
            if (c == 2'd0 && a < 2'd1) begin tag = "R8"; return '0; end
            if (c == 2'd1 && a < 2'd2) begin tag = "R8"; return '0; end
        end
        return 16'(1) << sgi_id;
    endfunction

    // One cycle: inputs already driven at a falling edge
    task automatic step();
        logic [15:0] e_line;
        logic [15:0] e_sgi;
        string       t_sgi;
        e_line = line_in & ~mdl_level & cfg_edge[31:16];
        e_sgi  = exp_sgi(t_sgi);
        @(posedge clk);
        @(negedge clk);
        check((e_line != 0) ? "R2" : "R3", {16'h0, pend_set[31:16]}, {16'h0, e_line});
        check(t_sgi, {16'h0, pend_set[15:0]}, {16'h0, e_sgi});
        check("R1", {16'h0, line_level}, {16'h0, line_in});
        mdl_level = line_in;
        sgi_valid = 1'b0;
    endtask

    task automatic request(input int id, input int grp, input bit ns);
        sgi_valid = 1'b1;
        sgi_id    = 4'(id);
        sgi_grp   = 2'(grp);
        sgi_ns    = ns;
        step();
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        unused_seed = $urandom(32'd12345);
        @(negedge clk);
        line_in = 16'hFFFF;
        sgi_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", pend_set, 32'h0);
        check("R10", {16'h0, line_level}, 32'h0);
        sgi_valid = 1'b0;
        line_in = '0;
        rst_n = 1'b1;
        mdl_level = '0;

        // R2 / R3 directed: rise, hold, fall on edge line; level line quiet
        cfg_edge = 32'h0001_0000;
        line_in = 16'h0003; step();
        step();
        line_in = 16'h0000; step();

        // R4: security disabled ignores modifier; group 0 remains group 0
        sec_disable = 1'b1;
        cfg_group = '0; cfg_grpmod = 32'h0000_0008;
        request(3, 0, 1'b1);
        request(3, 1, 1'b0);
        // R4: security enabled, modifier makes secure group 1
        sec_disable = 1'b0;
        request(3, 0, 1'b0);
        request(3, 1, 1'b0);
        // R5: secure group-1 request to group-0 interrupt
        request(4, 1, 1'b0);
        // R6: non-secure group-1 request to group-0 interrupt
        request(4, 2, 1'b0);
        request(4, 3, 1'b0);
        // R7 / R8: access level only for ID 5, at bits 11:10
        cfg_grpmod = 32'h0000_0030;
        cfg_access = 32'h0000_0800;
        request(5, 1, 1'b1);
        request(4, 1, 1'b1);
        cfg_access = 32'h0000_0400;
        request(5, 1, 1'b1);
        // R8: group 0 needs level 1; non-secure group 1 needs none
        cfg_grpmod = '0;
        request(6, 0, 1'b1);
        cfg_access = 32'h0000_1000;
        request(6, 0, 1'b1);
        cfg_group = 32'h0000_0080; cfg_access = '0;
        request(7, 2, 1'b1);

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            if (k % 40 == 0) begin
                cfg_group   = $urandom;
                cfg_grpmod  = $urandom;
                cfg_edge    = $urandom;
                cfg_access  = $urandom;
                sec_disable = ($urandom % 4) == 0;
            end
            if ($urandom % 2) line_in = line_in ^ 16'($urandom & $urandom);
            sgi_valid = ($urandom % 3) != 0;
            sgi_id    = 4'($urandom);
            sgi_grp   = 2'($urandom);
            sgi_ns    = 1'($urandom);
            step();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule